// File: doc/BRIEF.md
# Delayed-Sample Timing Error Detector

This block is a guarded pipeline register. It sits at the end of a combinational path. A main register captures the path's result on each main clock instant. A shadow register captures the same signal a fixed number of fast sampling cycles later. If a late-arriving transition or a transient upset makes the two samples differ, the stage raises an error flag. The shadow sample is treated as the correct value and is forced into the main register. The stage then stalls for one main period, so that downstream logic consumes the repaired value instead of a fresh capture.

The main instant and the delayed instant both come from one fast clock, `clk`. An internal phase counter runs over `DIV` fast cycles per main period. The main sample is taken on the edge that closes phase 0. The shadow sample is taken on the edge that closes phase `DELAY`. The comparison is taken on the edge that closes phase `DELAY+1`. `main_edge` lets a producer align to the main instant. `replay_out` exposes the shadow value used for recovery. Reset is synchronous and active high.

Top module: `tde_detect_stage`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `q_out`, `err_out`, `stall_out`, `replay_out` and the phase counter, whether or not an error is in progress.
- R2: When no stall is in progress, `q_out` takes the value `d_in` had at the edge that closes phase 0. Apart from a correction, `q_out` changes at no other edge.
- R3: The shadow register captures `d_in` at the edge that closes phase `DELAY`, and `replay_out` shows that value until the next shadow capture.
- R4: A mismatch between `q_out` and the shadow value at the edge that closes phase `DELAY+1` sets `err_out`. The flag then stays high for exactly `DIV` fast cycles, which is one main period, for each mismatch.
- R5: On a mismatch, the same edge that sets `err_out` loads the shadow value into `q_out`. This covers both a late transition and a single-bit flip at the main instant.
- R6: After a mismatch, `stall_out` is high for exactly one main period, starting at the next main edge. During that period the main edge does not load `d_in`, the shadow register does not load, and `q_out` holds the repaired value.
- R7: Changes on `d_in` after the shadow instant and before the next main instant have no effect on `q_out`, `replay_out` or `err_out`.
- R8: When both samples agree, `err_out` and `stall_out` stay low.
- R9: `main_edge` is high exactly during phase 0, once every `DIV` fast cycles. It is high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | WIDTH | Output of the guarded combinational path |
| q_out | output | WIDTH | Registered stage output, repaired on error |
| err_out | output | 1 | Mismatch flag, one main period per detected error |
| stall_out | output | 1 | High for the main period in which the repaired value is held |
| replay_out | output | WIDTH | Shadow sample used to restore the output |
| main_edge | output | 1 | High during the fast cycle that ends at a main sampling instant |

## Verification
The bench moves `d_in` between the main and shadow instants to model late transitions. It flips single bits, at the least and most significant positions, at the main instant only. It also moves `d_in` just after the shadow instant.

A design that compares at the wrong phase would flag the post-shadow change or miss the late one. One that corrects late, or not at all, would leave the stale value on `q_out`. Pulse lengths are checked at every phase. A flag that re-arms during the stall, or a stall that swallows the following capture, therefore shows up as a wrong value on the next main period.

Back-to-back error periods and a reset that lands in the middle of a pending error close the set.

// File: rtl/tde_pkg.sv
package tde_pkg;

   // width of a counter that must hold values 0 .. n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // per-phase strobes driven by the phase generator
   typedef struct packed {
      logic main_en;   // edge closing this cycle is the main instant
      logic shad_en;   // edge closing this cycle is the delayed instant
      logic cmp_en;    // edge closing this cycle resolves the comparison
   } tde_strobe_t;

   // comparator construction variants
   localparam int unsigned CMP_WORD    = 0;
   localparam int unsigned CMP_PER_BIT = 1;

endpackage

// File: rtl/tde_phase_gen.sv
module tde_phase_gen
   import tde_pkg::*;
#(
   parameter int unsigned DIV   = 8,
   parameter int unsigned DELAY = 3
) (
   input  logic        clk,
   input  logic        rst,
   output tde_strobe_t strobe_o
);

   localparam int unsigned PW = cnt_w(DIV);
   localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
   localparam logic [PW-1:0] PH_SHAD = PW'(DELAY);
   localparam logic [PW-1:0] PH_CMP  = PW'(DELAY + 1);

   generate
      if (DIV < 3) begin : g_bad_div
         initial $fatal(1, "tde_phase_gen: DIV must be at least 3");
      end
      if ((DELAY < 1) || (DELAY + 2 > DIV)) begin : g_bad_delay
         initial $fatal(1, "tde_phase_gen: DELAY must lie in 1 .. DIV-2");
      end
   endgenerate

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (ph_q == PH_LAST) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + PW'(1);
      end
   end

   always_comb begin
      strobe_o.main_en = (ph_q == '0);
      strobe_o.shad_en = (ph_q == PH_SHAD);
      strobe_o.cmp_en  = (ph_q == PH_CMP);
   end

endmodule

// File: rtl/tde_shadow_cmp.sv
module tde_shadow_cmp
   import tde_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned CMP_STYLE = CMP_PER_BIT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shad_en,
   input  logic             hold,
   input  logic [WIDTH-1:0] d_i,
   input  logic [WIDTH-1:0] main_i,
   output logic [WIDTH-1:0] shad_o,
   output logic             mismatch_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         initial $fatal(1, "tde_shadow_cmp: WIDTH must be at least 1");
      end
      if ((CMP_STYLE != CMP_WORD) && (CMP_STYLE != CMP_PER_BIT)) begin : g_bad_style
         initial $fatal(1, "tde_shadow_cmp: unknown CMP_STYLE");
      end
   endgenerate

   logic [WIDTH-1:0] shad_q;
   logic [WIDTH-1:0] diff;

   always_ff @(posedge clk) begin
      if (rst) begin
         shad_q <= '0;
      end else if (shad_en && !hold) begin
         shad_q <= d_i;
      end
   end

   generate
      if (CMP_STYLE == CMP_PER_BIT) begin : g_cmp_bits
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign diff[i] = shad_q[i] ^ main_i[i];
         end
      end else begin : g_cmp_word
         assign diff = shad_q ^ main_i;
      end
   endgenerate

   assign mismatch_o = |diff;
   assign shad_o     = shad_q;

endmodule

// File: rtl/tde_out_ctrl.sv
module tde_out_ctrl #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             main_en,
   input  logic             cmp_en,
   input  logic             mismatch_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic [WIDTH-1:0] shad_i,
   output logic [WIDTH-1:0] q_o,
   output logic             err_o,
   output logic             stall_o
);

   logic [WIDTH-1:0] q_q;
   logic             err_q;
   logic             pend_q;
   logic             stall_q;
   logic             hit;

   // a mismatch only counts outside a stall period
   assign hit = cmp_en && mismatch_i && !stall_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_q     <= '0;
         err_q   <= 1'b0;
         pend_q  <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         if (hit) begin
            q_q <= shad_i;
         end else if (main_en && !pend_q) begin
            q_q <= d_i;
         end

         if (cmp_en) begin
            err_q <= hit;
         end

         if (hit) begin
            pend_q <= 1'b1;
         end else if (main_en) begin
            pend_q <= 1'b0;
         end

         if (main_en) begin
            stall_q <= pend_q;
         end
      end
   end

   assign q_o     = q_q;
   assign err_o   = err_q;
   assign stall_o = stall_q;

endmodule

// File: rtl/tde_detect_stage.sv
module tde_detect_stage
   import tde_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned DIV       = 8,
   parameter int unsigned DELAY     = 3,
   parameter int unsigned CMP_STYLE = CMP_PER_BIT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out,
   output logic             err_out,
   output logic             stall_out,
   output logic [WIDTH-1:0] replay_out,
   output logic             main_edge
);

   tde_strobe_t      strobe;
   logic             main_en_w;
   logic             cmp_en_w;
   logic             mismatch;
   logic [WIDTH-1:0] shad_w;
   logic [WIDTH-1:0] q_w;
   logic             stall_w;

   tde_phase_gen #(
      .DIV   (DIV),
      .DELAY (DELAY)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .strobe_o (strobe)
   );

   assign main_en_w = strobe.main_en;
   assign cmp_en_w  = strobe.cmp_en;

   tde_shadow_cmp #(
      .WIDTH     (WIDTH),
      .CMP_STYLE (CMP_STYLE)
   ) u_shadow (
      .clk        (clk),
      .rst        (rst),
      .shad_en    (strobe.shad_en),
      .hold       (stall_w),
      .d_i        (d_in),
      .main_i     (q_w),
      .shad_o     (shad_w),
      .mismatch_o (mismatch)
   );

   tde_out_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .main_en    (main_en_w),
      .cmp_en     (cmp_en_w),
      .mismatch_i (mismatch),
      .d_i        (d_in),
      .shad_i     (shad_w),
      .q_o        (q_w),
      .err_o      (err_out),
      .stall_o    (stall_w)
   );

   assign q_out      = q_w;
   assign stall_out  = stall_w;
   assign replay_out = shad_w;
   assign main_edge  = main_en_w;

endmodule

// File: rtl/tde_detect_stage_chk.sv
module tde_detect_stage_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             main_en,
   input logic             cmp_en,
   input logic [WIDTH-1:0] q_out,
   input logic             err_out,
   input logic             stall_out
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (q_out == '0) && !err_out && !stall_out); // R1

   AST_Q_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
      (!main_en && !cmp_en) |=> $stable(q_out)); // R2

   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (err_out && !cmp_en) |=> err_out); // R4

   AST_ERR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      (!err_out && !cmp_en) |=> !err_out); // R4

   AST_STALL_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
      $rose(stall_out) |-> $past(err_out)); // R6

   AST_STALL_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
      (stall_out && main_en) |=> !stall_out); // R6

   AST_STALL_HOLDS_Q: assert property (@(posedge clk) disable iff (rst)
      (stall_out && !main_en) |=> $stable(q_out) && stall_out); // R6

   AST_NO_STALL_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
      (!stall_out && !main_en) |=> !stall_out); // R6

endmodule

bind tde_detect_stage tde_detect_stage_chk #(
   .WIDTH (WIDTH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .main_en   (main_en_w),
   .cmp_en    (cmp_en_w),
   .q_out     (q_out),
   .err_out   (err_out),
   .stall_out (stall_out)
);

// File: tb/tde_detect_stage_tb.sv
module tde_detect_stage_tb;

   localparam int unsigned W     = 8;
   localparam int unsigned DIV   = 4;
   localparam int unsigned DELAY = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] d_in = '0;
   logic [W-1:0] q_out;
   logic         err_out;
   logic         stall_out;
   logic [W-1:0] replay_out;
   logic         main_edge;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tde_detect_stage #(
      .WIDTH (W),
      .DIV   (DIV),
      .DELAY (DELAY)
   ) u_dut (
      .clk        (clk),
      .rst        (rst),
      .d_in       (d_in),
      .q_out      (q_out),
      .err_out    (err_out),
      .stall_out  (stall_out),
      .replay_out (replay_out),
      .main_edge  (main_edge)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one clean-or-erroneous main period; entered at the falling edge of phase 0
   // a: value at main instant, b: value at shadow instant, c: value after shadow
   task automatic run_period(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [W-1:0] c);
      logic bad;
      bad = (a != b);
      check("R9 main_edge phase0", 32'(main_edge), 32'd1);
      d_in = a;
      @(negedge clk);
      check("R9 main_edge phase1", 32'(main_edge), 32'd0);
      check("R2 capture at main edge", 32'(q_out), 32'(a));
      check("R6 stall low in normal period", 32'(stall_out), 32'd0);
      d_in = b;
      @(negedge clk);
      @(negedge clk);
      check("R3 shadow sample", 32'(replay_out), 32'(b));
      d_in = c;
      @(negedge clk);
      check("R4 R8 error flag", 32'(err_out), 32'(bad));
      check("R5 R7 output after compare", 32'(q_out), bad ? 32'(b) : 32'(a));
      check("R3 R7 shadow after late change", 32'(replay_out), 32'(b));
      check("R6 stall not yet", 32'(stall_out), 32'd0);
   endtask

   // the stall period that follows an error; v is the repaired value
   task automatic stall_period(input logic [W-1:0] v);
      d_in = ~v;
      @(negedge clk);
      check("R6 stall high", 32'(stall_out), 32'd1);
      check("R6 output held", 32'(q_out), 32'(v));
      check("R4 flag held phase1", 32'(err_out), 32'd1);
      @(negedge clk);
      check("R4 flag held phase2", 32'(err_out), 32'd1);
      d_in = v ^ 8'h0F;
      @(negedge clk);
      check("R4 flag held phase3", 32'(err_out), 32'd1);
      check("R6 shadow frozen", 32'(replay_out), 32'(v));
      @(negedge clk);
      check("R4 flag cleared after one period", 32'(err_out), 32'd0);
      check("R6 stall still high", 32'(stall_out), 32'd1);
      check("R6 output still held", 32'(q_out), 32'(v));
   endtask

   task automatic t_reset();
      rst = 1'b1;
      d_in = 8'hC3;
      @(negedge clk);
      @(negedge clk);
      check("R1 q cleared", 32'(q_out), 32'd0);
      check("R1 err cleared", 32'(err_out), 32'd0);
      check("R1 stall cleared", 32'(stall_out), 32'd0);
      check("R1 replay cleared", 32'(replay_out), 32'd0);
      rst = 1'b0;
      check("R9 main_edge after reset", 32'(main_edge), 32'd1);
   endtask

   task automatic t_clean();
      run_period(8'h3C, 8'h3C, 8'h3C);
      run_period(8'hA5, 8'hA5, 8'hA5);
      run_period(8'hFF, 8'hFF, 8'hFF);
      run_period(8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_late();
      run_period(8'h10, 8'h90, 8'h90);
      stall_period(8'h90);
      run_period(8'h21, 8'h21, 8'h21);
   endtask

   task automatic t_flip();
      run_period(8'h5A ^ 8'h01, 8'h5A, 8'h5A);
      stall_period(8'h5A);
      run_period(8'h5A ^ 8'h80, 8'h5A, 8'h5A);
      stall_period(8'h5A);
   endtask

   task automatic t_after_shadow();
      run_period(8'h55, 8'h55, 8'hAA);
      run_period(8'h66, 8'h66, 8'h99);
   endtask

   task automatic t_back_to_back();
      run_period(8'h01, 8'h03, 8'h03);
      stall_period(8'h03);
      run_period(8'h70, 8'h7F, 8'h00);
      stall_period(8'h7F);
      run_period(8'h44, 8'h44, 8'h44);
   endtask

   task automatic t_reset_mid();
      run_period(8'h0C, 8'hC0, 8'hC0);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset clears err mid error", 32'(err_out), 32'd0);
      check("R1 reset clears stall mid error", 32'(stall_out), 32'd0);
      check("R1 reset clears q mid error", 32'(q_out), 32'd0);
      check("R1 reset clears replay mid error", 32'(replay_out), 32'd0);
      rst = 1'b0;
      run_period(8'h3E, 8'h3E, 8'h3E);
   endtask

   initial begin
      t_reset();
      t_clean();
      t_late();
      t_flip();
      t_after_shadow();
      t_back_to_back();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule